// File: doc/BRIEF.md
# Compressed Extension-Subset Instruction Expander

This block turns one 16-bit compressed instruction from the byte/halfword memory-access and single-register arithmetic subset into the equivalent 32-bit base-ISA instruction. A fetch or decode stage sits in front of it and places the halfword on `instr_i` with `valid_i` high. One clock later the expanded word appears on `instr_o`, together with `valid_o` and an `illegal_o` flag.

Five configuration pins enable the subset and the extensions that some of its encodings depend on. These are the bit-manipulation basic ops, the address-generation ops, the multiply ops and 64-bit mode. An encoding whose extensions are disabled is flagged illegal, and so is any halfword outside the subset's encodings. When `illegal_o` is set, the expanded word is all zeros. Register fields are 3 bits wide and name x8 to x15.

Top module: `zcb_expander`

## Requirements
- R1: Quadrant 00 with bits[15:10]=100000 gives a zero-extending byte load: opcode 0000011, funct3 100, rd = x8+bits[4:2], rs1 = x8+bits[9:7], imm = {bit5, bit6}, zero-extended to 12 bits (0 to 3).
- R2: Quadrant 00 with bits[15:10]=100001 gives a halfword load with imm = {bit5, 0}. Bit 6 = 0 selects funct3 101 (zero-extending) and bit 6 = 1 selects funct3 001 (sign-extending).
- R3: Quadrant 00 with bits[15:10]=100010 gives a byte store in S-type form: opcode 0100011, funct3 000, rs2 = x8+bits[4:2], rs1 = x8+bits[9:7], offset {bit5, bit6} in instruction bits[8:7].
- R4: Quadrant 00 with bits[15:10]=100011 gives a halfword store with funct3 001 and offset {bit5, 0}. If bit 6 is set, the instruction is illegal.
- R5: Quadrant 01 with bits[15:10]=100111 and bits[6:5]=11 uses sub-code bits[4:2]. Sub-code 000 gives andi rd,rd,0xFF and 101 gives xori rd,rd,-1 (opcode 0010011). Both need only the subset enable. rd = x8+bits[9:7].
- R6: Sub-code 001 gives sext.b (imm12 0x604, funct3 001, opcode 0010011). Sub-code 011 gives sext.h (imm12 0x605). Sub-code 010 gives zext.h (funct7 0000100, rs2 x0, funct3 100), with opcode 0110011 in 32-bit mode or 0111011 in 64-bit mode. All three need the bit-manipulation enable.
- R7: Sub-code 100 gives add.uw rd,rd,x0 (funct7 0000100, rs2 x0, funct3 000, opcode 0111011). It needs the address-generation enable and 64-bit mode.
- R8: bits[6:5]=10 in the same space gives mul rd,rd,rs2 (funct7 0000001, rs2 = x8+bits[4:2], funct3 000, opcode 0110011). It needs the multiply enable.
- R9: The following are all illegal: any halfword outside R1 to R8, sub-codes 110 and 111, and any halfword when the subset enable is low. An illegal result drives `instr_o` to all zeros.
- R10: Latency is exactly one clock. `valid_o` equals `valid_i` from the previous edge. Asynchronous reset clears `valid_o`, `instr_o` and `illegal_o`.
- R11: While `valid_i` is low, `instr_o` and `illegal_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Halfword on instr_i is valid |
| instr_i | input | 16 | Compressed instruction |
| en_zcb_i | input | 1 | Enables the whole subset |
| en_zbb_i | input | 1 | Enables the bit-manipulation extends |
| en_zba_i | input | 1 | Enables the 32-to-64 zero extend |
| en_mul_i | input | 1 | Enables multiply |
| rv64_i | input | 1 | 64-bit mode |
| valid_o | output | 1 | Registered valid |
| instr_o | output | 32 | Expanded instruction, zero when illegal |
| illegal_o | output | 1 | Halfword is illegal under the configuration |

## Verification
All widths follow from the instruction formats, so the bench builds the block with its only configuration. Every enable combination is a runtime pin setting. The bench therefore covers each sub-code with its own enable cleared and set, and zext.h and the 32-to-64 extend with 64-bit mode toggled. It also tests all four offsets of the byte forms and the forbidden bit 6 of the halfword store. Random halfwords, weighted toward the two opcode spaces, are applied with random enables and stalls, so that the hold behaviour between valid strobes is covered as well.

// File: rtl/zcb_pkg.sv
package zcb_pkg;
  localparam int unsigned HW   = 16;
  localparam int unsigned IW   = 32;
  localparam int unsigned RW   = 5;
  localparam int unsigned CRW  = 3;
  localparam int unsigned OPW  = 7;
  localparam int unsigned F3W  = 3;
  localparam int unsigned IMMW = 12;

  localparam logic [OPW-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPW-1:0] OPC_STORE = 7'b0100011;
  localparam logic [OPW-1:0] OPC_OPIMM = 7'b0010011;
  localparam logic [OPW-1:0] OPC_OP    = 7'b0110011;
  localparam logic [OPW-1:0] OPC_OP32  = 7'b0111011;

  typedef struct packed {
    logic zcb;
    logic zbb;
    logic zba;
    logic mul;
    logic rv64;
  } zcb_cfg_t;

  // 3-bit register field -> x8..x15
  function automatic logic [RW-1:0] creg(input logic [CRW-1:0] c);
    return {2'b01, c};
  endfunction

  function automatic logic [IW-1:0] fmt_i(input logic [IMMW-1:0] imm, input logic [RW-1:0] rs1,
                                         input logic [F3W-1:0] f3, input logic [RW-1:0] rd,
                                         input logic [OPW-1:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [IW-1:0] fmt_s(input logic [IMMW-1:0] imm, input logic [RW-1:0] rs2,
                                         input logic [RW-1:0] rs1, input logic [F3W-1:0] f3,
                                         input logic [OPW-1:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction

  function automatic logic [IW-1:0] fmt_r(input logic [6:0] f7, input logic [RW-1:0] rs2,
                                         input logic [RW-1:0] rs1, input logic [F3W-1:0] f3,
                                         input logic [RW-1:0] rd, input logic [OPW-1:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction
endpackage

// File: rtl/zcb_ldst_dec.sv
module zcb_ldst_dec
  import zcb_pkg::*;
(
  input  logic [HW-1:0] instr_i,
  input  logic          en_zcb_i,
  output logic          legal_o,
  output logic [IW-1:0] word_o
);
  logic            match;
  logic            ok;
  logic [1:0]      sel;
  logic [RW-1:0]   rbase, rdat;
  logic [IMMW-1:0] off_b, off_h;

  assign match = (instr_i[1:0] == 2'b00) && (instr_i[15:12] == 4'b1000);
  assign sel   = instr_i[11:10];
  assign rbase = creg(instr_i[9:7]);
  assign rdat  = creg(instr_i[4:2]);
  // offset bits are swapped in the byte forms
  assign off_b = {{(IMMW-2){1'b0}}, instr_i[5], instr_i[6]};
  assign off_h = {{(IMMW-2){1'b0}}, instr_i[5], 1'b0};

  always_comb begin
    ok     = 1'b1;
    word_o = '0;
    unique case (sel)
      2'b00: word_o = fmt_i(off_b, rbase, 3'b100, rdat, OPC_LOAD);
      2'b01: word_o = fmt_i(off_h, rbase, instr_i[6] ? 3'b001 : 3'b101, rdat, OPC_LOAD);
      2'b10: word_o = fmt_s(off_b, rdat, rbase, 3'b000, OPC_STORE);
      2'b11: begin
        word_o = fmt_s(off_h, rdat, rbase, 3'b001, OPC_STORE);
        ok     = !instr_i[6];
      end
      default: ok = 1'b0;
    endcase
  end

  assign legal_o = match && ok && en_zcb_i;
endmodule

// File: rtl/zcb_alu_dec.sv
module zcb_alu_dec
  import zcb_pkg::*;
(
  input  logic [HW-1:0] instr_i,
  input  zcb_cfg_t      cfg_i,
  output logic          legal_o,
  output logic          srcdst_o,
  output logic [IW-1:0] word_o
);
  logic          match;
  logic          ok;
  logic [RW-1:0] rsd, rs2;

  assign match = (instr_i[1:0] == 2'b01) && (instr_i[15:10] == 6'b100111) && instr_i[6];
  assign rsd   = creg(instr_i[9:7]);
  assign rs2   = creg(instr_i[4:2]);

  always_comb begin
    ok     = 1'b0;
    word_o = '0;
    if (!instr_i[5]) begin
      word_o = fmt_r(7'b0000001, rs2, rsd, 3'b000, rsd, OPC_OP);
      ok     = cfg_i.mul;
    end else begin
      unique case (instr_i[4:2])
        3'b000: begin word_o = fmt_i(12'h0ff, rsd, 3'b111, rsd, OPC_OPIMM); ok = 1'b1; end
        3'b001: begin word_o = fmt_i(12'h604, rsd, 3'b001, rsd, OPC_OPIMM); ok = cfg_i.zbb; end
        3'b010: begin
          word_o = fmt_r(7'b0000100, '0, rsd, 3'b100, rsd, cfg_i.rv64 ? OPC_OP32 : OPC_OP);
          ok     = cfg_i.zbb;
        end
        3'b011: begin word_o = fmt_i(12'h605, rsd, 3'b001, rsd, OPC_OPIMM); ok = cfg_i.zbb; end
        3'b100: begin
          word_o = fmt_r(7'b0000100, '0, rsd, 3'b000, rsd, OPC_OP32);
          ok     = cfg_i.zba && cfg_i.rv64;
        end
        3'b101: begin word_o = fmt_i(12'hfff, rsd, 3'b100, rsd, OPC_OPIMM); ok = 1'b1; end
        default: ok = 1'b0;
      endcase
    end
  end

  assign legal_o  = match && ok && cfg_i.zcb;
  assign srcdst_o = match && instr_i[5];
endmodule

// File: rtl/zcb_expander.sv
module zcb_expander
  import zcb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [15:0]   instr_i,
  input  logic          en_zcb_i,
  input  logic          en_zbb_i,
  input  logic          en_zba_i,
  input  logic          en_mul_i,
  input  logic          rv64_i,
  output logic          valid_o,
  output logic [31:0]   instr_o,
  output logic          illegal_o
);
  zcb_cfg_t      cfg;
  logic          ls_legal, alu_legal, alu_srcdst;
  logic [IW-1:0] ls_word, alu_word, nxt_word;
  logic          nxt_ill;
  logic          valid_q, ill_q;
  logic [IW-1:0] word_q;

  assign cfg = '{zcb: en_zcb_i, zbb: en_zbb_i, zba: en_zba_i, mul: en_mul_i, rv64: rv64_i};

  zcb_ldst_dec u_ldst (
    .instr_i (instr_i),
    .en_zcb_i(en_zcb_i),
    .legal_o (ls_legal),
    .word_o  (ls_word)
  );

  zcb_alu_dec u_alu (
    .instr_i (instr_i),
    .cfg_i   (cfg),
    .legal_o (alu_legal),
    .srcdst_o(alu_srcdst),
    .word_o  (alu_word)
  );

  always_comb begin
    nxt_ill  = !(ls_legal || alu_legal);
    nxt_word = ls_legal ? ls_word : (alu_legal ? alu_word : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      ill_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        word_q <= nxt_word;
        ill_q  <= nxt_ill;
      end
    end
  end

  assign valid_o   = valid_q;
  assign instr_o   = word_q;
  assign illegal_o = ill_q;

  p_illegal_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (instr_o == '0));
  p_no_zcb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !en_zcb_i) |=> illegal_o);
  p_valid_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(instr_o) && $stable(illegal_o)));
  p_sh_bit6_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[1:0] == 2'b00 && instr_i[15:10] == 6'b100011 && instr_i[6]) |=> illegal_o);
  p_mul_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !en_mul_i && instr_i[1:0] == 2'b01 && instr_i[15:10] == 6'b100111
     && instr_i[6:5] == 2'b10) |=> illegal_o);
  p_srcdst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && alu_srcdst && alu_legal) |=> (instr_o[11:7] == instr_o[19:15]));
endmodule

// File: tb/tb_zcb_expander.sv
`timescale 1ns/1ps
module tb_zcb_expander;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [4:0]  cfg = '0;  // {zcb, zbb, zba, mul, rv64}
  logic        valid_o, illegal_o;
  logic [31:0] instr_o;

  int checks = 0;
  int errors = 0;

  logic        e_valid = 1'b0;
  logic [31:0] e_word = '0;
  logic        e_ill = 1'b0;
  string       e_tag = "R10";

  localparam logic [4:0] ALL = 5'b11111;

  always #5 clk = ~clk;

  zcb_expander dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .en_zcb_i(cfg[4]), .en_zbb_i(cfg[3]), .en_zba_i(cfg[2]), .en_mul_i(cfg[1]),
    .rv64_i(cfg[0]), .valid_o(valid_o), .instr_o(instr_o), .illegal_o(illegal_o)
  );

  function automatic void ref_model(input logic [15:0] h, input logic [4:0] c,
                                    output logic [31:0] w, output logic ill, output string tag);
    int  rb, rl, off;
    bit  ok;
    rb = 8 + int'(h[9:7]);
    rl = 8 + int'(h[4:2]);
    w = '0; ill = 1'b1; tag = "R9"; ok = 0;
    if (h[1:0] == 2'b00 && h[15:12] == 4'b1000) begin
      off = 2 * int'(h[5]);
      if (!h[10]) off = off + int'(h[6]);
      case (h[11:10])
        2'd0: begin tag = "R1"; ok = 1; w = (off << 20) | (rb << 15) | (4 << 12) | (rl << 7) | 3; end
        2'd1: begin tag = "R2"; ok = 1; w = (off << 20) | (rb << 15) | ((h[6] ? 1 : 5) << 12) | (rl << 7) | 3; end
        2'd2: begin tag = "R3"; ok = 1; w = (rl << 20) | (rb << 15) | (off << 7) | 35; end
        default: begin tag = "R4"; ok = !h[6]; w = (rl << 20) | (rb << 15) | (1 << 12) | (off << 7) | 35; end
      endcase
      ok = ok && c[4];
    end else if (h[1:0] == 2'b01 && h[15:10] == 6'b100111 && h[6]) begin
      if (!h[5]) begin
        tag = "R8"; ok = c[1];
        w = (1 << 25) | (rl << 20) | (rb << 15) | (rb << 7) | 51;
      end else begin
        case (h[4:2])
          3'd0: begin tag = "R5"; ok = 1; w = (255 << 20) | (rb << 15) | (7 << 12) | (rb << 7) | 19; end
          3'd5: begin tag = "R5"; ok = 1; w = (4095 << 20) | (rb << 15) | (4 << 12) | (rb << 7) | 19; end
          3'd1: begin tag = "R6"; ok = c[3]; w = (1540 << 20) | (rb << 15) | (1 << 12) | (rb << 7) | 19; end
          3'd3: begin tag = "R6"; ok = c[3]; w = (1541 << 20) | (rb << 15) | (1 << 12) | (rb << 7) | 19; end
          3'd2: begin tag = "R6"; ok = c[3]; w = (4 << 25) | (rb << 15) | (4 << 12) | (rb << 7) | (c[0] ? 59 : 51); end
          3'd4: begin tag = "R7"; ok = c[2] && c[0]; w = (4 << 25) | (rb << 15) | (rb << 7) | 59; end
          default: begin tag = "R9"; ok = 0; end
        endcase
      end
      ok = ok && c[4];
    end
    if (ok) ill = 1'b0;
    else    w = '0;
  endfunction

  task automatic compare();
    checks++;
    if (valid_o !== e_valid) begin
      errors++;
      $display("FAIL R10 valid_o actual=%0b expected=%0b", valid_o, e_valid);
    end
    checks++;
    if (instr_o !== e_word || illegal_o !== e_ill) begin
      errors++;
      $display("FAIL %s instr_o/illegal_o actual=%08h/%0b expected=%08h/%0b (in=%04h cfg=%05b)",
               e_tag, instr_o, illegal_o, e_word, e_ill, instr_i, cfg);
    end
  endtask

  // compare the previous cycle's result, then drive the next input
  task automatic step(input logic [15:0] h, input logic [4:0] c, input logic v);
    logic [31:0] w;
    logic        ill;
    string       tag;
    @(negedge clk);
    compare();
    instr_i = h; cfg = c; valid_i = v;
    e_valid = v;
    if (v) begin
      ref_model(h, c, w, ill, tag);
      e_word = w; e_ill = ill; e_tag = tag;
    end else begin
      e_tag = "R11";
    end
  endtask

  function automatic logic [15:0] enc_ls(input logic [1:0] s, input logic b6, input logic b5,
                                         input logic [2:0] rb, input logic [2:0] rl);
    return {4'b1000, s, rb, b6, b5, rl, 2'b00};
  endfunction

  function automatic logic [15:0] enc_alu(input logic [2:0] r, input logic [1:0] k, input logic [2:0] s);
    return {6'b100111, r, k, s, 2'b01};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    e_tag = "R10";
    compare();  // reset state
    rst_ni = 1'b1;

    // R1..R4 memory forms, every offset
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        step(enc_ls(2'(s), o[0], o[1], 3'(s + o), 3'(7 - o)), ALL, 1'b1);
    // R4 forbidden bit 6 again, R1 with subset disabled (R9)
    step(enc_ls(2'b11, 1'b1, 1'b0, 3'd2, 3'd5), ALL, 1'b1);
    step(enc_ls(2'b00, 1'b1, 1'b1, 3'd1, 3'd1), 5'b01111, 1'b1);

    // R5..R9 register forms, all sub-codes under several configurations
    for (int c = 0; c < 32; c++)
      for (int s = 0; s < 8; s++) begin
        step(enc_alu(3'(s), 2'b11, 3'(s)), 5'(c), 1'b1);
        if (s < 2) step(enc_alu(3'(c), 2'b10, 3'(s + 3)), 5'(c), 1'b1);
      end

    // R11 hold with changing inputs, R9 outside spaces
    step(enc_alu(3'd3, 2'b11, 3'd0), ALL, 1'b1);
    step(16'hffff, ALL, 1'b0);
    step(16'h0000, 5'b00000, 1'b0);
    step(16'h0000, ALL, 1'b1);
    step(enc_alu(3'd4, 2'b00, 3'd1), ALL, 1'b1);
    step(enc_alu(3'd4, 2'b01, 3'd1), ALL, 1'b1);
    step(16'h9c00 | 16'h0002, ALL, 1'b1);
    step(16'hffff, ALL, 1'b1);

    // random sweep
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] h;
      h = 16'($urandom);
      case ($urandom % 3)
        0: h = {4'b1000, h[11:2], 2'b00};
        1: h = {6'b100111, h[9:2], 2'b01};
        default: ;
      endcase
      step(h, 5'($urandom), 1'($urandom % 4 != 0));
    end

    // reset during operation clears outputs (R10)
    step(enc_alu(3'd1, 2'b11, 3'd5), ALL, 1'b1);
    @(negedge clk);
    compare();
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    e_valid = 1'b0; e_word = '0; e_ill = 1'b0; e_tag = "R10";
    compare();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule